// File: doc/BRIEF.md
# Power-fail protected byte SRAM

This block is a synthesizable model of a 2048 x 8 static memory with built-in supply-loss protection. It has an asynchronous-style control port: active-low chip select, output enable and write strobe, an 11-bit address, an 8-bit write data bus, and an 8-bit read data bus with a separate drive-enable. The tri-state buffer sits outside the block. All controls are sampled on a fast system clock that is much quicker than any access, and are assumed synchronous to it.

Three discrete power-state inputs feed the protection logic:
- a supply-in-tolerance level;
- a supply-above-switchover level;
- a battery-low sample that is taken when the supply rises past switchover.

While the supply is bad, and for a programmable recovery interval after it returns, the memory accepts no write and never drives its outputs. A write that is open when protection rises is dropped, so every byte keeps its old value. A low battery seen at power-up raises a warning flag. That flag swallows exactly one write, which clears it, and normal operation then resumes. The warning flag and the protection state are brought out as debug outputs.

Top module: `guarded_sram`

## Requirements
- R1: The array holds 2048 bytes selected by `addr`. A byte written to one address reads back unchanged, and writes to other addresses do not alter it.
- R2: While `ce_n` is 1, `dout_en` is 0 and `dout` is 0. A low `we_n` pulse given while `ce_n` is 1 changes no location.
- R3: With `ce_n`=0, `oe_n`=0, `we_n`=1 and no protection, `dout_en` is 1 and `dout` shows the byte at `addr` in the same cycle, with no clock edge needed. With `oe_n`=1 and `we_n`=1, `dout_en` is 0.
- R4: A write window is open while both `ce_n` and `we_n` are 0. The byte is stored at the first clock edge that samples either of them at 1. It uses the address and data sampled at the last edge inside the window, and reads see it from that edge on.
- R5: While `we_n` is 0, `dout_en` is 0, even if `ce_n` and `oe_n` are both 0.
- R6: While `vcc_ok` is 0, `protect_o` is 1, `dout_en` is 0 and no write is stored. A write window that is open when protection rises is discarded, and no location changes.
- R7: At each clock edge that samples `vcc_above_so` at 1 after it was 0 (including the first edge after reset), `batt_flag_o` takes the value of `batt_low`. While the flag is 1, the next write window ends without storing anything and clears the flag. Later writes store normally.
- R8: Every edge that samples `vcc_ok` at 0 reloads a recovery counter to `REC_CYCLES`. Each edge with `vcc_ok` at 1 counts it down. `protect_o` is 1 while `vcc_ok` is 0 or the counter is non-zero. So protection stays on for `REC_CYCLES` edges after the supply returns.
- R9: During and right after reset, `protect_o` is 1, `batt_flag_o` is 0 and `dout_en` is 0. Protection clears `REC_CYCLES` edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 11 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data (0 when not driving) |
| dout_en | output | 1 | Drive enable for the external tri-state buffer |
| vcc_ok | input | 1 | Supply within tolerance |
| vcc_above_so | input | 1 | Supply above the battery switchover level |
| batt_low | input | 1 | Battery-low sample, taken when the supply rises |
| batt_flag_o | output | 1 | Debug: battery warning flag |
| protect_o | output | 1 | Debug: write/output protection active |

## Verification
Read data and `dout_en` are combinational, so the bench checks them 1 ns after it changes the inputs on a falling clock edge.

A write is stored at the first rising edge that samples the closing strobe. The bench therefore opens the window on one falling edge, closes it on the next, and reads no earlier than the falling edge after that.

The battery flag is updated at the rising edge that samples the switchover rise. Protection drops exactly `REC_CYCLES` rising edges after `vcc_ok` returns, and the bench samples `protect_o` one edge before and on that edge.

A shadow array and a shadow flag in the bench supply all expected read values.

// File: rtl/gsr_pkg.sv
// Package: shared sizes for the guarded SRAM.
// Assumes: byte-wide storage, power-of-two depth.
package gsr_pkg;
    localparam int unsigned GSR_AW = 11;
    localparam int unsigned GSR_DW = 8;
    localparam int unsigned GSR_DEPTH = 1 << GSR_AW;

    // Decoded access mode of the control port
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_mode_t;
endpackage

// File: rtl/gsr_power_ctl.sv
// Module: gsr_power_ctl
// Tracks the supply state. It produces the protection level (supply bad or
// recovery still counting) and the battery warning flag, which is sampled on
// the switchover rise and cleared by the first write that ends.
// Assumes: power inputs are already synchronous to clk.
module gsr_power_ctl #(
    parameter int unsigned REC_CYCLES = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_ok,
    input  logic vcc_above_so,
    input  logic batt_low,
    input  logic wr_end,
    output logic protect,
    output logic batt_flag
);
    localparam int unsigned CW = $clog2(REC_CYCLES + 1);
    localparam logic [CW-1:0] REC_LOAD = CW'(REC_CYCLES);

    logic [CW-1:0] rec_cnt;
    logic          so_q;
    logic          so_rise;

    assign so_rise = vcc_above_so && !so_q;
    assign protect = !vcc_ok || (rec_cnt != '0);

    // Recovery counter: reload while the supply is bad, count down after it returns
    always_ff @(posedge clk) begin
        if (!rst_n)
            rec_cnt <= REC_LOAD;
        else if (!vcc_ok)
            rec_cnt <= REC_LOAD;
        else if (rec_cnt != '0)
            rec_cnt <= rec_cnt - 1'b1;
    end

    // Switchover history, used to find the power-up edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            so_q <= 1'b0;
        else
            so_q <= vcc_above_so;
    end

    // Battery warning flag: set from the sample at power-up, cleared by the next write end
    always_ff @(posedge clk) begin
        if (!rst_n)
            batt_flag <= 1'b0;
        else if (so_rise)
            batt_flag <= batt_low;
        else if (wr_end)
            batt_flag <= 1'b0;
    end

    // R8
    recovery_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_ok |=> protect);

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (batt_flag && wr_end && !so_rise) |=> !batt_flag);
endmodule

// File: rtl/gsr_access_dec.sv
// Module: gsr_access_dec
// Decodes the active-low control port into read enable and write events.
// A write window is open while select and strobe are both low and the block
// is unprotected. The window is stored when it closes, using the address and
// data sampled at its last cycle. It is dropped if protection cut it off or
// if the battery flag swallows it.
// Assumes: controls are synchronous to clk and held for several cycles.
module gsr_access_dec
    import gsr_pkg::*;
#(
    parameter int unsigned AW = GSR_AW,
    parameter int unsigned DW = GSR_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    input  logic          protect,
    input  logic          batt_flag,
    output logic          rd_en,
    output logic          wr_end,
    output logic          wr_commit,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    acc_mode_t mode;
    logic      wr_open_q;

    // Mode decode: select gates everything, strobe wins over output enable
    always_comb begin
        if (protect || ce_n)
            mode = ACC_IDLE;
        else if (!we_n)
            mode = ACC_WRITE;
        else if (!oe_n)
            mode = ACC_READ;
        else
            mode = ACC_IDLE;
    end

    assign rd_en     = (mode == ACC_READ);
    assign wr_end    = wr_open_q && (ce_n || we_n) && !protect;
    assign wr_commit = wr_end && !batt_flag;

    // Window tracker: remember that a write is open and capture its latest address and data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_open_q <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            wr_open_q <= (mode == ACC_WRITE);
            if (mode == ACC_WRITE) begin
                wr_addr <= addr;
                wr_data <= din;
            end
        end
    end

    // R6
    protect_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        protect |-> (!wr_commit && !rd_en));

    // R7
    flag_swallow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> !batt_flag);

    // R4
    commit_needs_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> $past(!ce_n && !we_n));
endmodule

// File: rtl/gsr_array.sv
// Module: gsr_array
// Byte storage with one synchronous write port and one combinational read port.
// Assumes: contents are not reset, as with a real static array.
module gsr_array #(
    parameter int unsigned AW = 11,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store one byte when a write commits
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/guarded_sram.sv
// Module: guarded_sram (top)
// A 2048 x 8 static memory with supply-loss protection. It wires the power
// controller, the access decoder and the array together, and gates the read
// bus with its drive enable.
// Assumes: the external tri-state buffer is driven from dout_en.
module guarded_sram
    import gsr_pkg::*;
#(
    parameter int unsigned AW         = GSR_AW,
    parameter int unsigned DW         = GSR_DW,
    parameter int unsigned REC_CYCLES = 200000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    input  logic          vcc_ok,
    input  logic          vcc_above_so,
    input  logic          batt_low,
    output logic          batt_flag_o,
    output logic          protect_o
);
    logic          protect;
    logic          batt_flag;
    logic          rd_en;
    logic          wr_end;
    logic          wr_commit;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] rd_data;

    gsr_power_ctl #(.REC_CYCLES(REC_CYCLES)) pwr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .vcc_ok      (vcc_ok),
        .vcc_above_so(vcc_above_so),
        .batt_low    (batt_low),
        .wr_end      (wr_end),
        .protect     (protect),
        .batt_flag   (batt_flag)
    );

    gsr_access_dec #(.AW(AW), .DW(DW)) dec_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .addr     (addr),
        .din      (din),
        .protect  (protect),
        .batt_flag(batt_flag),
        .rd_en    (rd_en),
        .wr_end   (wr_end),
        .wr_commit(wr_commit),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    gsr_array #(.AW(AW), .DW(DW)) mem_i (
        .clk    (clk),
        .wr_en  (wr_commit),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(addr),
        .rd_data(rd_data)
    );

    // Output gating: drive the bus only during an unprotected read
    assign dout_en     = rd_en;
    assign dout        = rd_en ? rd_data : '0;
    assign batt_flag_o = batt_flag;
    assign protect_o   = protect;

    // R2
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> (!dout_en && dout == '0));

    // R5
    strobe_mutes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !dout_en);

    // R6
    supply_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_ok |-> (protect_o && !dout_en));
endmodule

// File: tb/guarded_sram_tb_top.sv
// Bench for guarded_sram: fixed-seed random accesses plus directed power cases,
// checked against a shadow array. Inputs change on falling edges only.
module guarded_sram_tb_top;
    localparam int unsigned REC = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [10:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;
    logic        vcc_ok = 1'b1, vcc_above_so = 1'b1, batt_low = 1'b0;
    logic        batt_flag_o, protect_o;

    int unsigned n_run = 0;
    int unsigned n_fail = 0;
    int unsigned cyc = 0;
    logic [7:0]  model [2048];
    logic        model_flag = 1'b0;

    guarded_sram #(.REC_CYCLES(REC)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .vcc_ok(vcc_ok), .vcc_above_so(vcc_above_so), .batt_low(batt_low),
        .batt_flag_o(batt_flag_o), .protect_o(protect_o)
    );

    always #5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run = n_run + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Expected effect of one complete write window on the shadow state
    function automatic void model_write(input logic [10:0] a, input logic [7:0] d);
        if (model_flag) model_flag = 1'b0;
        else model[a] = d;
    endfunction

    task automatic do_write(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; din = d;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        model_write(a, d);
        @(negedge clk);
    endtask

    task automatic do_read(input logic [10:0] a, input string tag);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        #1;
        chk(dout_en === 1'b1, {tag, " dout_en"}, int'(dout_en), 1);
        chk(dout === model[a], {tag, " dout"}, int'(dout), int'(model[a]));
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wait_recovery();
        idle(REC + 2);
        chk(protect_o === 1'b0, "R8 recovered", int'(protect_o), 0);
    endtask

    initial begin
        logic [10:0] a;
        logic [7:0]  d;
        void'($urandom(32'd1234));

        // R9 reset state
        idle(3);
        #1;
        chk(protect_o === 1'b1, "R9 protect in reset", int'(protect_o), 1);
        chk(dout_en === 1'b0, "R9 dout_en in reset", int'(dout_en), 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(batt_flag_o === 1'b0, "R9 flag after reset", int'(batt_flag_o), 0);
        chk(protect_o === 1'b1, "R9 protect after reset", int'(protect_o), 1);
        idle(REC - 2); #1;
        chk(protect_o === 1'b1, "R9 protect one edge early", int'(protect_o), 1);
        @(negedge clk); #1;
        chk(protect_o === 1'b0, "R9 protect cleared", int'(protect_o), 0);

        // R1 fill every location with a known pattern
        for (int i = 0; i < 2048; i++) do_write(11'(i), 8'(i * 7 + 3));
        do_read(11'd0, "R1 first");
        do_read(11'd2047, "R1 last");
        do_read(11'd1024, "R1 middle");

        // R3 output enable high: no drive
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; addr = 11'd5; #1;
        chk(dout_en === 1'b0, "R3 oe_n high", int'(dout_en), 0);
        ce_n = 1'b1;

        // R2 deselected strobe is ignored
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b0; addr = 11'd9; din = 8'hEE; #1;
        chk(dout_en === 1'b0 && dout === 8'h00, "R2 deselect quiet", int'(dout), 0);
        @(negedge clk);
        we_n = 1'b1; oe_n = 1'b1;
        do_read(11'd9, "R2 ignored write");

        // R5 strobe mutes an active read; R4 last-sample data is stored
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = 11'd33; #1;
        chk(dout_en === 1'b1, "R5 read before strobe", int'(dout_en), 1);
        @(negedge clk);
        we_n = 1'b0; din = 8'h11; #1;
        chk(dout_en === 1'b0, "R5 strobe mutes", int'(dout_en), 0);
        @(negedge clk);
        din = 8'h77;
        @(negedge clk);
        we_n = 1'b1; oe_n = 1'b1; ce_n = 1'b1;
        model_write(11'd33, 8'h77);
        @(negedge clk);
        do_read(11'd33, "R4 last sample");

        // R4 window closed by select instead of strobe
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; addr = 11'd40; din = 8'h3C;
        @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        we_n = 1'b1;
        model_write(11'd40, 8'h3C);
        do_read(11'd40, "R4 select close");

        // R1 random mix
        for (int i = 0; i < 400; i++) begin
            a = 11'($urandom);
            d = 8'($urandom);
            if ($urandom % 2 == 0) do_write(a, d);
            else do_read(a, "R1 random");
        end

        // R6 supply loss in the middle of a write
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; addr = 11'd100; din = ~model[100];
        @(negedge clk);
        vcc_ok = 1'b0;
        @(negedge clk);
        oe_n = 1'b0; we_n = 1'b1; #1;
        chk(protect_o === 1'b1, "R6 protect", int'(protect_o), 1);
        chk(dout_en === 1'b0, "R6 no drive", int'(dout_en), 0);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        idle(2);
        vcc_ok = 1'b1;
        // R8 exact recovery length
        idle(REC - 1); #1;
        chk(protect_o === 1'b1, "R8 one edge early", int'(protect_o), 1);
        @(negedge clk); #1;
        chk(protect_o === 1'b0, "R8 on time", int'(protect_o), 0);
        do_read(11'd100, "R6 aborted byte");
        do_read(11'd101, "R6 neighbour");
        do_read(11'd99, "R6 neighbour");

        // R7 battery low at power-up swallows one write
        @(negedge clk);
        vcc_ok = 1'b0; vcc_above_so = 1'b0;
        idle(3);
        batt_low = 1'b1; vcc_above_so = 1'b1;
        @(negedge clk);
        batt_low = 1'b0; vcc_ok = 1'b1;
        #1;
        chk(batt_flag_o === 1'b1, "R7 flag set", int'(batt_flag_o), 1);
        model_flag = 1'b1;
        wait_recovery();
        do_write(11'd200, ~model[200]);
        #1;
        chk(batt_flag_o === 1'b0, "R7 flag cleared", int'(batt_flag_o), 0);
        do_read(11'd200, "R7 swallowed write");
        do_write(11'd200, 8'hA5);
        do_read(11'd200, "R7 next write stored");

        // R7 good battery at power-up leaves the flag clear
        @(negedge clk);
        vcc_ok = 1'b0; vcc_above_so = 1'b0;
        idle(3);
        vcc_above_so = 1'b1;
        @(negedge clk);
        vcc_ok = 1'b1; #1;
        chk(batt_flag_o === 1'b0, "R7 good battery", int'(batt_flag_o), 0);
        wait_recovery();
        do_write(11'd201, 8'h5A);
        do_read(11'd201, "R7 normal write");

        idle(2);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule